// File: doc/BRIEF.md
# Cascaded 16-bit Match Timer

This block joins two 8-bit timer halves into one 16-bit up-counter. The low half holds the least significant byte of the count and of the compare value, and the upper half holds the most significant byte. The low half also supplies the clock selection, the start control and the interrupt. The count advances on ticks from a programmable divider of the system clock, or on rising edges of an external count pin that is synchronized into the system clock domain. When the count equals the 16-bit compare value, the next tick returns it to zero and sets an interrupt flag. The flag stays set until the interrupt controller acknowledges it.

Software reaches the block through a byte-wide register port with six addresses: two control registers, two compare bytes and two count readback bytes. Joined operation needs a link bit and a reserved all-ones code in the upper control register. The upper half never raises an interrupt of its own.

A three-state machine sequences the counter. In `ST_IDLE` the counter and the divider are held at zero. In `ST_RUN` ticks advance the count. In `ST_PAUSE` the count and the divider are frozen. The transitions are:
- `arm`: `ST_IDLE` to `ST_RUN` when the block is enabled, in timer mode and linked, with continue set.
- `hold`: `ST_RUN` to `ST_PAUSE` when continue is cleared.
- `resume`: `ST_PAUSE` to `ST_RUN` when continue is set again.
- `park`: any state to `ST_IDLE` when enable, timer mode or the link is lost.

`ST_IDLE` goes directly to `ST_PAUSE` if the block is armed with continue clear.

Top module: `cascade_timer16`

## Requirements
- R1: After reset, every readable address (0 to 5) returns 00h and `irq` is low.
- R2: Counting happens only when the upper control register (address 1) has bit 7 set and bits 3:0 equal 1111b. Otherwise the count reads 0000h and `irq` stays low.
- R3: The low control register (address 0) has this layout: bit 7 is enable, bit 6 is unused, bit 5 is the mode bit (0 selects timer operation), bits 4:2 are the clock select, bit 1 is continue and bit 0 is start/clear. Counting needs enable=1, mode=0 and continue=1.
- R4: Clock select codes 1 to 7 divide the system clock by 2, 4, 8, 32, 128, 512 and 2048 respectively. The count advances once per divided period.
- R5: The count increments from 0000h. On the tick where the count equals the compare value, it returns to 0000h and sets `irq`. With compare value D and divide ratio N, successive interrupts are (D+1)*N cycles apart.
- R6: The compare value is written with its low byte at address 2 and its high byte at address 3. The count reads back with its low byte at address 4 and its high byte at address 5.
- R7: `irq` stays high until `irq_ack` is pulsed. A match in the same cycle as an acknowledge leaves the flag set.
- R8: With continue=0 the count is held at its current value.
- R9: Writing 1 to bit 0 of address 0 clears the count and the divider. The bit reads back as 0 afterwards.
- R10: Clock select code 0 counts rising edges of `ext_clk`, after a two-flop synchronizer. Each rising edge advances the count by one.
- R11: A compare value written while the timer runs is used for the next comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| ext_clk | input | 1 | External count input, asynchronous |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | Interrupt request flag |

## Verification
The bench builds the block with its default parameters: 8-bit halves and an 11-bit divider. The 11-bit divider makes the full set of divide ratios, including the 2048 setting, reachable within a short run. Because the halves are 8 bits wide, compare values that straddle the byte boundary (such as 0102h) test that the two halves are joined correctly. The 16-bit maximum compare value is used as an unreachable limit during the pause, clear and external-count tests.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2
    } ctmr_state_e;

    localparam int LO_EN_BIT   = 7;
    localparam int LO_MODE_BIT = 5;
    localparam int LO_SEL_MSB  = 4;
    localparam int LO_SEL_LSB  = 2;
    localparam int LO_CONT_BIT = 1;
    localparam int LO_ST_BIT   = 0;
    localparam int HI_LINK_BIT = 7;
    localparam logic [3:0] HI_LINK_CODE = 4'b1111;

    localparam logic [2:0] ADR_CTL_LO = 3'd0;
    localparam logic [2:0] ADR_CTL_HI = 3'd1;
    localparam logic [2:0] ADR_CMP_LO = 3'd2;
    localparam logic [2:0] ADR_CMP_HI = 3'd3;
    localparam logic [2:0] ADR_CNT_LO = 3'd4;
    localparam logic [2:0] ADR_CNT_HI = 3'd5;

    // log2 of the divide ratio for select codes 1..7: 1,2,3,5,7,9,11
    function automatic logic [3:0] div_shift(input logic [2:0] code);
        if (code <= 3'd3) return {1'b0, code};
        else              return {code, 1'b0} - 4'd3;
    endfunction
endpackage

// File: rtl/ctmr_regs.sv
module ctmr_regs
    import ctmr_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          addr,
    input  logic [HALF_W-1:0]   wdata,
    input  logic [2*HALF_W-1:0] cnt,
    output logic [HALF_W-1:0]   rdata,
    output logic [2*HALF_W-1:0] cmp,
    output logic [2:0]          sel,
    output logic                cont,
    output logic                armed,
    output logic                clr
);
    logic [HALF_W-1:0] ctl_lo_q, ctl_hi_q;
    logic              st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_lo_q <= '0;
            ctl_hi_q <= '0;
            cmp      <= '0;
            st_q     <= 1'b0;
        end else begin
            st_q <= 1'b0;
            if (wr_en) begin
                unique case (addr)
                    ADR_CTL_LO: begin
                        ctl_lo_q <= {wdata[HALF_W-1:1], 1'b0};
                        st_q     <= wdata[LO_ST_BIT];
                    end
                    ADR_CTL_HI: ctl_hi_q <= wdata;
                    ADR_CMP_LO: cmp[HALF_W-1:0] <= wdata;
                    ADR_CMP_HI: cmp[2*HALF_W-1:HALF_W] <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (addr)
            ADR_CTL_LO: rdata = ctl_lo_q | {{(HALF_W-1){1'b0}}, st_q};
            ADR_CTL_HI: rdata = ctl_hi_q;
            ADR_CMP_LO: rdata = cmp[HALF_W-1:0];
            ADR_CMP_HI: rdata = cmp[2*HALF_W-1:HALF_W];
            ADR_CNT_LO: rdata = cnt[HALF_W-1:0];
            ADR_CNT_HI: rdata = cnt[2*HALF_W-1:HALF_W];
            default:    rdata = '0;
        endcase
    end

    assign sel   = ctl_lo_q[LO_SEL_MSB:LO_SEL_LSB];
    assign cont  = ctl_lo_q[LO_CONT_BIT];
    assign clr   = st_q;
    assign armed = ctl_lo_q[LO_EN_BIT] && !ctl_lo_q[LO_MODE_BIT]
                && ctl_hi_q[HI_LINK_BIT] && (ctl_hi_q[3:0] == HI_LINK_CODE);

    // R9
    st_self_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q && !(wr_en && addr == ADR_CTL_LO && wdata[LO_ST_BIT])) |=> !st_q);
endmodule

// File: rtl/ctmr_prescaler.sv
module ctmr_prescaler
    import ctmr_pkg::*;
#(
    parameter int PSC_W     = 11,
    parameter int SYNC_LEN  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clr,
    input  logic [2:0] sel,
    input  logic       ext_clk,
    output logic       tick
);
    logic [SYNC_LEN-1:0] sync_q;
    logic                ext_prev_q;
    logic [PSC_W-1:0]    psc_q;
    logic [PSC_W:0]      mask_ext;
    logic [PSC_W-1:0]    mask;
    logic                ext_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q     <= '0;
            ext_prev_q <= 1'b0;
        end else begin
            sync_q     <= {sync_q[SYNC_LEN-2:0], ext_clk};
            ext_prev_q <= sync_q[SYNC_LEN-1];
        end
    end

    assign ext_rise = sync_q[SYNC_LEN-1] && !ext_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   psc_q <= '0;
        else if (clr) psc_q <= '0;
        else if (run) psc_q <= psc_q + 1'b1;
    end

    always_comb begin
        mask_ext = ({{PSC_W{1'b0}}, 1'b1} << div_shift(sel)) - 1'b1;
        mask     = mask_ext[PSC_W-1:0];
    end

    always_comb begin
        if (!run || clr)     tick = 1'b0;
        else if (sel == '0)  tick = ext_rise;
        else                 tick = ((psc_q & mask) == mask);
    end

    // R10
    ext_tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel == '0) |-> (sync_q[SYNC_LEN-1] && !ext_prev_q));
    // R8
    psc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> (psc_q == $past(psc_q)));
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             cont,
    input  logic             clr,
    input  logic             tick,
    input  logic             irq_ack,
    input  logic [CNT_W-1:0] cmp,
    output ctmr_state_e      state,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);
    ctmr_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  state_nx = !armed ? ST_IDLE : (cont ? ST_RUN : ST_PAUSE);
            ST_RUN:   state_nx = !armed ? ST_IDLE : (cont ? ST_RUN : ST_PAUSE);
            ST_PAUSE: state_nx = !armed ? ST_IDLE : (cont ? ST_RUN : ST_PAUSE);
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            if (irq_ack) irq <= 1'b0;
            unique case (state)
                ST_IDLE: cnt <= '0;
                ST_RUN: begin
                    if (clr) cnt <= '0;
                    else if (tick) begin
                        if (cnt == cmp) begin
                            cnt <= '0;
                            irq <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_PAUSE: if (clr) cnt <= '0;
                default: cnt <= '0;
            endcase
        end
    end

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tick && !clr && cnt == cmp) |=> (cnt == '0 && irq));
    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);
    // R8
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE && !clr) |=> (cnt == $past(cnt)));
    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (cnt == '0));
endmodule

// File: rtl/cascade_timer16.sv
module cascade_timer16
    import ctmr_pkg::*;
#(
    parameter int HALF_W   = 8,
    parameter int PSC_W    = 11,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] rdata,
    input  logic              ext_clk,
    input  logic              irq_ack,
    output logic              irq
);
    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0] cmp, cnt;
    logic [2:0]       sel;
    logic             cont, armed, clr, tick;
    ctmr_state_e      state;

    ctmr_regs #(.HALF_W(HALF_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt(cnt), .rdata(rdata), .cmp(cmp), .sel(sel), .cont(cont),
        .armed(armed), .clr(clr)
    );

    ctmr_prescaler #(.PSC_W(PSC_W), .SYNC_LEN(SYNC_LEN)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(state == ST_RUN),
        .clr(clr || state == ST_IDLE), .sel(sel), .ext_clk(ext_clk), .tick(tick)
    );

    ctmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .armed(armed), .cont(cont), .clr(clr),
        .tick(tick), .irq_ack(irq_ack), .cmp(cmp), .state(state),
        .cnt(cnt), .irq(irq)
    );
endmodule

// File: tb/cascade_timer16_test.sv
module cascade_timer16_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ext_clk = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int exp_q[$];
    bit fresh = 1'b1, auto_ack = 1'b1;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cascade_timer16 uut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic rd_cnt(output int v);
        logic [7:0] lo, hi;
        rd(3'd4, lo); rd(3'd5, hi);
        v = {hi, lo};
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected interrupt spacing and compares
    int last_t = 0;
    bit irq_prev = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (irq_ack) irq_ack = 1'b0;
            if (irq && !irq_prev) begin
                if (fresh) fresh = 1'b0;
                else if (exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    check(cyc - last_t == e, "R5 interval", cyc - last_t, e);
                end
                last_t = cyc;
                if (auto_ack) irq_ack = 1'b1;
            end
            irq_prev = irq;
        end
    end

    // driver: configures a schedule and pushes expected spacing (R4, R5, R6)
    task automatic run_sched(input logic [2:0] sel, input int d, input int n);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h8F);
        wr(3'd2, d[7:0]);
        wr(3'd3, d[15:8]);
        fresh = 1'b1;
        for (int i = 0; i < n; i++) exp_q.push_back((d + 1) << ((sel <= 3) ? sel : 2*sel - 3));
        wr(3'd0, 8'h82 | {3'b000, sel, 2'b00});
        wait (exp_q.size() == 0);
        wr(3'd0, 8'h00);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        while (cyc < 150000) @(negedge clk);
        check(1'b0, "watchdog", cyc, 150000);
        finish_up();
    end

    initial begin
        logic [7:0] v;
        int a, b;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        for (int i = 0; i < 6; i++) begin
            rd(i[2:0], v);
            check(v == 8'h00, "R1 reset readback", v, 0);
        end
        check(irq == 1'b0, "R1 irq low", irq, 0);

        // R2 link code not all ones: no counting
        wr(3'd1, 8'h8E); wr(3'd2, 8'h03); wr(3'd0, 8'h86);
        idle(60); rd_cnt(a);
        check(a == 0, "R2 partial link code", a, 0);
        wr(3'd1, 8'h0F); idle(40); rd_cnt(a);
        check(a == 0 && irq == 1'b0, "R2 link bit clear", a, 0);
        // R3 mode bit set blocks counting
        wr(3'd1, 8'h8F); wr(3'd0, 8'hA6); idle(40); rd_cnt(a);
        check(a == 0, "R3 mode bit blocks", a, 0);
        wr(3'd0, 8'h00);

        // R4 R5 R6 every divider code, including byte straddle
        run_sched(3'd1, 3, 3);
        run_sched(3'd2, 4, 2);
        run_sched(3'd3, 16'h0102, 2);
        run_sched(3'd4, 2, 2);
        run_sched(3'd5, 1, 2);
        run_sched(3'd6, 1, 2);
        run_sched(3'd7, 1, 2);
        rd(3'd2, v); check(v == 8'h01, "R6 compare low byte", v, 1);

        // R11 compare rewritten while running
        wr(3'd1, 8'h8F); wr(3'd2, 8'hFF); wr(3'd3, 8'h7F);
        fresh = 1'b1;
        exp_q.push_back(80); exp_q.push_back(80);
        wr(3'd0, 8'h8E);
        idle(20);
        wr(3'd3, 8'h00); wr(3'd2, 8'h09);
        wait (exp_q.size() == 0);
        check(1'b1, "R11 new compare applied", 80, 80);
        wr(3'd0, 8'h00);

        // R7 flag held without acknowledge, cleared by it
        auto_ack = 1'b0;
        wr(3'd2, 8'h03); wr(3'd3, 8'h00); wr(3'd0, 8'h86);
        wait (irq == 1'b1);
        idle(50);
        check(irq == 1'b1, "R7 flag held", irq, 1);
        wr(3'd0, 8'h00);
        @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0; #1;
        check(irq == 1'b0, "R7 acknowledge clears", irq, 0);
        auto_ack = 1'b1;

        // R8 pause holds count
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd0, 8'h86);
        idle(40);
        wr(3'd0, 8'h84);
        idle(3); rd_cnt(a); idle(20); rd_cnt(b);
        check(a == b && a != 0, "R8 paused count", b, a);

        // R9 start/clear
        wr(3'd0, 8'h85);
        idle(2); rd_cnt(a);
        check(a == 0, "R9 count cleared", a, 0);
        rd(3'd0, v);
        check(v == 8'h84, "R9 start bit self clears", v, 8'h84);
        wr(3'd0, 8'h00);

        // R10 external edges
        wr(3'd0, 8'h82);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); ext_clk = 1'b1; idle(4);
            ext_clk = 1'b0; idle(4);
        end
        idle(6); rd_cnt(a);
        check(a == 5, "R10 external edge count", a, 5);
        wr(3'd0, 8'h00);

        idle(5);
        finish_up();
    end
endmodule